// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets synchronous logic use an external asynchronous static RAM of 128K words by 9 bits. A host offers one request at a time on a valid/ready port. Each request carries a direction flag, a 17-bit word address and 9 bits of write data. The block latches the request. It then plays out the strobe sequence the memory needs on active-low chip select, write enable and output enable. It also drives a stable address bus. The shared data bus is modelled as three signals: an output value, an input value and a drive enable, to be combined by a tristate pad outside the block.

The memory has no clock, so every phase length is a parameter counted in cycles of the block's clock. The integrator picks these counts so that each nanosecond minimum of the memory is met at the chosen clock period:
- write pulse width
- address setup before the write strobe
- recovery after the access
- read access time

A write holds chip select and write enable low together, and output enable stays high for the whole write. A read holds chip select and output enable low for the read wait count. It samples the data bus in the last cycle of that wait and returns the value with a one-cycle valid pulse.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, with no request accepted, `req_ready` is 1, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is taken only in a cycle where both `req_valid` and `req_ready` are 1. `req_ready` then stays 0 for SETUP_CYC+PULSE_CYC+RECOV_CYC cycles after a write (`req_write`=1), or RDWAIT_CYC+RECOV_CYC cycles after a read (`req_write`=0). A `req_valid` pulse while `req_ready` is 0 changes no memory word.
- R3: A write first holds `mem_cs_n` low with `mem_we_n` high for exactly SETUP_CYC cycles. It then holds `mem_cs_n` and `mem_we_n` both low for exactly PULSE_CYC consecutive cycles, and `mem_we_n` is never low while `mem_cs_n` is high.
- R4: `mem_oe_n` is 1 in every cycle of a write. `mem_we_n` is 1 in every cycle of a read. `mem_addr` changes only in a cycle where `mem_we_n` is 1.
- R5: `mem_dq_oe` is 1 only in the cycles where `mem_we_n` is low plus the one cycle after it rises, so PULSE_CYC+1 cycles per write. In those cycles `mem_dq_out` carries the accepted write data.
- R6: A read holds `mem_cs_n` and `mem_oe_n` low for exactly RDWAIT_CYC cycles and samples `mem_dq_in` in the last of them. In the next cycle `rsp_valid` is 1 for one cycle and `rsp_rdata` holds the sample. `rsp_rdata` keeps that value until the next read completes.
- R7: After the active phase of every access, `mem_cs_n` is 1 for RECOV_CYC cycles before `req_ready` returns to 1.
- R8: While `mem_cs_n` is low, `mem_addr` equals the address accepted with the current request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 9 | Data for a write |
| rsp_valid | output | 1 | One-cycle pulse: read data is present |
| rsp_rdata | output | 9 | Last data read, held |
| mem_addr | output | 17 | Address bus to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 9 | Value to place on the data bus |
| mem_dq_in | input | 9 | Value seen on the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The bench fills 64 addresses, each with its own low six bits and a distinct high part. It reads them all back, overwrites the odd ones with inverted data and reads everything again. These steps tell apart lost writes, address bits swapped or dropped, and stale read data. The memory model returns the inverted word until output enable has been low for the full wait. A block that samples early therefore returns the wrong data, and one that never drives the bus stores nothing. Request pulses made during a busy read, followed by a re-read of the target word, show whether such requests are ignored. Every access also has its phase lengths counted at the pins and compared with the parameters.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

    localparam int unsigned MEM_ADDR_W = 17;
    localparam int unsigned MEM_DATA_W = 9;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_PULSE = 3'd2,
        PH_READ  = 3'd3,
        PH_RECOV = 3'd4
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    function automatic strobe_t strobes_for(input phase_e ph, input logic hold_drive);
        strobe_t s;
        s = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        case (ph)
            PH_SETUP: s.cs_n = 1'b0;
            PH_PULSE: begin
                s.cs_n  = 1'b0;
                s.we_n  = 1'b0;
                s.dq_oe = 1'b1;
            end
            PH_READ: begin
                s.cs_n = 1'b0;
                s.oe_n = 1'b0;
            end
            PH_RECOV: s.dq_oe = hold_drive;
            default: ;
        endcase
        return s;
    endfunction

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_ctrl_pkg::*;
#(
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned PULSE_CYC  = 2,
    parameter int unsigned RECOV_CYC  = 1,
    parameter int unsigned RDWAIT_CYC = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    start_write,
    output logic    ready,
    output logic    sample,
    output strobe_t strb
);
    localparam int unsigned MAX_CYC = max_of4(SETUP_CYC, PULSE_CYC, RECOV_CYC, RDWAIT_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    phase_e           phase_q, phase_d;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             zero;
    logic             hold_q;

    asram_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .zero     (zero)
    );

    always_comb begin
        phase_d  = phase_q;
        load     = 1'b0;
        load_val = '0;
        case (phase_q)
            PH_IDLE: if (start) begin
                load = 1'b1;
                if (start_write) begin
                    phase_d  = PH_SETUP;
                    load_val = CNT_W'(SETUP_CYC - 1);
                end else begin
                    phase_d  = PH_READ;
                    load_val = CNT_W'(RDWAIT_CYC - 1);
                end
            end
            PH_SETUP: if (zero) begin
                phase_d  = PH_PULSE;
                load     = 1'b1;
                load_val = CNT_W'(PULSE_CYC - 1);
            end
            PH_PULSE, PH_READ: if (zero) begin
                phase_d  = PH_RECOV;
                load     = 1'b1;
                load_val = CNT_W'(RECOV_CYC - 1);
            end
            PH_RECOV: if (zero) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            hold_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            hold_q  <= (phase_q == PH_PULSE) && zero;
        end
    end

    assign ready  = (phase_q == PH_IDLE);
    assign sample = (phase_q == PH_READ) && zero;
    assign strb   = strobes_for(phase_q, hold_q);
endmodule

// File: rtl/asram_capture.sv
module asram_capture #(
    parameter int unsigned DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            valid <= 1'b0;
        end else begin
            valid <= sample;
            if (sample) rdata <= din;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W     = MEM_ADDR_W,
    parameter int unsigned DATA_W     = MEM_DATA_W,
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned PULSE_CYC  = 2,
    parameter int unsigned RECOV_CYC  = 1,
    parameter int unsigned RDWAIT_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    logic              accept;
    logic              sample;
    strobe_t           strb;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    asram_seq #(
        .SETUP_CYC  (SETUP_CYC),
        .PULSE_CYC  (PULSE_CYC),
        .RECOV_CYC  (RECOV_CYC),
        .RDWAIT_CYC (RDWAIT_CYC)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .start_write (req_write),
        .ready       (req_ready),
        .sample      (sample),
        .strb        (strb)
    );

    asram_capture #(.DATA_W(DATA_W)) cap_i (
        .clk    (clk),
        .rst    (rst),
        .sample (sample),
        .din    (mem_dq_in),
        .rdata  (rsp_rdata),
        .valid  (rsp_valid)
    );

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign mem_cs_n   = strb.cs_n;
    assign mem_we_n   = strb.we_n;
    assign mem_oe_n   = strb.oe_n;
    assign mem_dq_oe  = strb.dq_oe;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned DATA_W    = 9,
    parameter int unsigned PULSE_CYC = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    logic [31:0] we_run;

    always_ff @(posedge clk) begin
        if (rst) we_run <= '0;
        else     we_run <= mem_we_n ? 32'd0 : we_run + 32'd1;
    end

    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (we_run < PULSE_CYC));

    assert_we_needs_cs_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);

    assert_write_no_oe_R4: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    assert_addr_move_we_high_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> mem_we_n);

    assert_addr_held_R8: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    assert_drive_window_R5: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n || $past(!mem_we_n)));

    assert_ready_idle_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_cs_n);

    assert_rsp_single_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_rsp_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!mem_oe_n));

    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> $stable(rsp_rdata));
endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PULSE_CYC (PULSE_CYC)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;
    localparam int S  = 2;
    localparam int P  = 3;
    localparam int RC = 2;
    localparam int RW = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [8:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [8:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [8:0]  mem_dq_out;
    logic [8:0]  mem_dq_in;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [8:0] mem [64];
    logic [8:0] exp_mem [64];
    int oe_run = 0;

    always #4 clk = ~clk;

    asram_ctrl #(
        .SETUP_CYC(S), .PULSE_CYC(P), .RECOV_CYC(RC), .RDWAIT_CYC(RW)
    ) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    // memory model: stores while strobed and driven; read data is wrong
    // until output enable has been low for the whole wait
    always @(posedge clk) begin
        if (!mem_cs_n && !mem_we_n && mem_dq_oe) mem[mem_addr[5:0]] <= mem_dq_out;
        oe_run <= (!mem_cs_n && !mem_oe_n) ? oe_run + 1 : 0;
    end

    assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n)
                     ? ((oe_run >= RW - 1) ? mem[mem_addr[5:0]] : ~mem[mem_addr[5:0]])
                     : 9'h1FF;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic access(input bit wr, input logic [16:0] a, input logic [8:0] d,
                          input bit poke, input logic [16:0] poke_a);
        int busy = 0, setup = 0, pulse = 0, rdw = 0, drv = 0, rspn = 0;
        logic [8:0] rd = '0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && busy < 100) begin
            busy++;
            if (poke && busy == 1) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = poke_a; req_wdata = ~d;
            end else if (poke && busy == 2) begin
                req_valid = 1'b0;
            end
            if (!mem_cs_n && mem_we_n && mem_oe_n) setup++;
            if (!mem_we_n) begin
                pulse++;
                chk(mem_oe_n == 1'b1, "R4 oe high in write", mem_oe_n, 1);
                chk(mem_dq_out == d, "R5 write data on bus", mem_dq_out, d);
            end
            if (!mem_oe_n) begin
                rdw++;
                chk(mem_we_n == 1'b1, "R4 we high in read", mem_we_n, 1);
            end
            if (!mem_cs_n) chk(mem_addr == a, "R8 address held", mem_addr, a);
            if (mem_dq_oe) drv++;
            if (rsp_valid) begin
                rspn++;
                rd = rsp_rdata;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (wr) begin
            chk(busy == S + P + RC, "R2 write busy length", busy, S + P + RC);
            chk(setup == S, "R3 setup length", setup, S);
            chk(pulse == P, "R3 pulse length", pulse, P);
            chk(drv == P + 1, "R5 drive window", drv, P + 1);
            chk(busy - setup - pulse == RC, "R7 write recovery", busy - setup - pulse, RC);
            exp_mem[a[5:0]] = d;
        end else begin
            chk(busy == RW + RC, "R2 read busy length", busy, RW + RC);
            chk(rdw == RW, "R6 read wait length", rdw, RW);
            chk(drv == 0, "R5 no drive in read", drv, 0);
            chk(busy - rdw == RC, "R7 read recovery", busy - rdw, RC);
            chk(rspn == 1, "R6 one rsp pulse", rspn, 1);
            chk(rd == exp_mem[a[5:0]], "R6 read data", rd, exp_mem[a[5:0]]);
        end
    endtask

    function automatic logic [16:0] addr_of(input int i);
        return 17'((i << 11) | i);
    endfunction

    function automatic logic [8:0] data_of(input int i);
        return 9'((i * 37 + 5) & 9'h1FF);
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i] = '0;
            exp_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(req_ready && mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
            "R1 outputs in reset", 0, 1);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(req_ready && mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
            "R1 outputs idle after reset", 0, 1);

        for (int i = 0; i < 64; i++) access(1'b1, addr_of(i), data_of(i), 1'b0, '0);
        for (int i = 0; i < 64; i++) access(1'b0, addr_of(i), '0, 1'b0, '0);

        // R6: read data held across a later write
        begin
            logic [8:0] last;
            last = rsp_rdata;
            access(1'b1, addr_of(1), data_of(1), 1'b0, '0);
            chk(rsp_rdata == last, "R6 rdata held", rsp_rdata, last);
        end

        // R2: request pulses during a busy read are ignored
        for (int i = 0; i < 64; i += 8) begin
            access(1'b0, addr_of(i), '0, 1'b1, addr_of(i));
            access(1'b0, addr_of(i), '0, 1'b0, '0);
        end

        for (int i = 1; i < 64; i += 2) access(1'b1, addr_of(i), ~data_of(i), 1'b0, '0);
        for (int i = 0; i < 64; i++) access(1'b0, addr_of(i), '0, 1'b0, '0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule